// File: doc/BRIEF.md
# Bit-6 Channel-Interleave Address Swizzler

When two memory channels are interleaved, the CPU flips channel on address bit 6, which is every 64 bytes. The graphics engine also folds higher address bits into its channel choice, and it does so differently for X-tiled and Y-tiled surfaces. This block rewrites bit 6 of a physical address so that both views of the same tiled surface reach the same bytes. The rewrite XORs a set of source bits into bit 6. The set is chosen by the tiling type of the access and by a swizzle mode that is held separately for X and Y.

A small decoder works out the two modes from a memory-controller configuration word. A 2-bit kind input says how to read that word:
- no swizzle at all;
- a channel-addressing word;
- a pair of channel size fields;
- a fixed interleave.

The decoder may find the configuration unreadable or undeterminable. In that case it falls back to no swizzle and raises a sticky request that pages be kept pinned. The mode registers only take new values while a quiesce input is high, so traffic never sees a mode change partway through. The address path itself is purely combinational.

Top module: `bit6_swizzler`

## Requirements
- R1: After reset, `mode_x` and `mode_y` are 0 (NONE) and `pin_pages` is 0.
- R2: A linear access passes its address through unchanged. Linear is `tile` = 00, and the code 11 is treated as linear.
- R3: An X-tiled access (`tile` = 01) changes only bit 6. It XORs bit 6 with the source bits named by `mode_x`. The mode codes are:

  | Code | Name | Bits XORed into bit 6 |
  |---|---|---|
  | 0 | NONE | none |
  | 1 | 9 | 9 |
  | 2 | 9_10 | 9, 10 |
  | 3 | 9_11 | 9, 11 |
  | 4 | 9_10_11 | 9, 10, 11 |
  | 5 | 9_17 | 9, 17 |
  | 6 | 9_10_17 | 9, 10, 17 |

- R4: A Y-tiled access (`tile` = 10) does the same, using `mode_y`.
- R5: With `cfg_kind` = 01, the word's bits [1:0] give the addressing mode. The values 00 (single channel) and 01 (asymmetric dual channel) give NONE for both X and Y.
- R6: With `cfg_kind` = 01 and addressing 10 (interleaved), the modes depend on two bits of the word:
  - If bit 10 (channel XOR off) is set, X is 9_10 and Y is 9.
  - Otherwise, if bit 9 (bit-17 select) is clear, X is 9_10_11 and Y is 9_11.
  - Otherwise X is 9_10_17 and Y is 9_17.
- R7: The other kinds decode as follows:
  - `cfg_kind` = 00 gives NONE for both.
  - `cfg_kind` = 11 gives X 9_10 and Y 9.
  - `cfg_kind` = 10 compares the two size fields, word[7:0] and word[15:8]. If they are equal it gives 9_10 / 9; otherwise NONE.
- R8: With `cfg_kind` = 01, two words are undeterminable: a word of all ones, and addressing value 11. Either one loads NONE for both modes and sets `pin_pages`. The flag then stays set until reset.
- R9: While `quiesce` is low, changes on `cfg_kind` and `cfg_word` have no effect on `mode_x`, `mode_y` or `pin_pages`.
- R10: The mode registers load from the decoder on each rising clock edge where `quiesce` is high. `addr_out` follows `tile` and `addr_in` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| quiesce | input | 1 | Allows the mode registers to load |
| cfg_kind | input | 2 | How `cfg_word` is interpreted |
| cfg_word | input | 32 | Memory-controller configuration word |
| tile | input | 2 | Tiling type of the access |
| addr_in | input | 32 | Physical address before the swizzle |
| addr_out | output | 32 | Swizzled physical address |
| mode_x | output | 3 | Held mode for X-tiled accesses |
| mode_y | output | 3 | Held mode for Y-tiled accesses |
| pin_pages | output | 1 | Sticky request to keep pages pinned |

## Verification
The bench drives the configuration inputs with `quiesce` high one falling edge before a rising edge. It lowers `quiesce` at the next falling edge and reads the mode outputs there, exactly one register stage after the load. Address results carry no register, so each address and tile pattern is sampled 1 ns after it is driven, within the same cycle. The hold behaviour is checked by changing the configuration across several edges with `quiesce` low, then reading the modes unchanged.

// File: rtl/swz_pkg.sv
package swz_pkg;

    typedef enum logic [2:0] {
        SWZ_NONE     = 3'd0,
        SWZ_9        = 3'd1,
        SWZ_9_10     = 3'd2,
        SWZ_9_11     = 3'd3,
        SWZ_9_10_11  = 3'd4,
        SWZ_9_17     = 3'd5,
        SWZ_9_10_17  = 3'd6
    } swz_mode_e;

    typedef enum logic [1:0] {
        TILE_LINEAR = 2'b00,
        TILE_X      = 2'b01,
        TILE_Y      = 2'b10,
        TILE_RSVD   = 2'b11
    } tile_e;

    typedef enum logic [1:0] {
        KIND_OFF   = 2'b00,
        KIND_CHAN  = 2'b01,
        KIND_SIZE  = 2'b10,
        KIND_FIXED = 2'b11
    } cfg_kind_e;

    // channel-addressing word layout
    localparam int CH_AM_LSB   = 0;
    localparam int CH_SEL17    = 9;
    localparam int CH_XOR_OFF  = 10;

    localparam logic [1:0] AM_SINGLE = 2'b00;
    localparam logic [1:0] AM_ASYM   = 2'b01;
    localparam logic [1:0] AM_ILV    = 2'b10;

    localparam int SWZ_DST = 6;

    typedef struct packed {
        logic b17;
        logic b11;
        logic b10;
        logic b9;
    } swz_src_t;

    typedef struct packed {
        swz_mode_e mx;
        swz_mode_e my;
        logic      unknown;
    } swz_dec_t;

    function automatic logic swz_flip(swz_mode_e m, swz_src_t s);
        logic f;
        case (m)
            SWZ_9:       f = s.b9;
            SWZ_9_10:    f = s.b9 ^ s.b10;
            SWZ_9_11:    f = s.b9 ^ s.b11;
            SWZ_9_10_11: f = s.b9 ^ s.b10 ^ s.b11;
            SWZ_9_17:    f = s.b9 ^ s.b17;
            SWZ_9_10_17: f = s.b9 ^ s.b10 ^ s.b17;
            default:     f = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/swz_cfg_decode.sv
module swz_cfg_decode
    import swz_pkg::*;
#(
    parameter int CFG_W  = 32,
    parameter int SIZE_W = 8
) (
    input  logic [1:0]       kind,
    input  logic [CFG_W-1:0] word,
    output swz_dec_t         dec
);
    localparam int AM_W = 2;

    logic [AM_W-1:0]   am;
    logic [SIZE_W-1:0] size0, size1;

    assign am    = word[CH_AM_LSB +: AM_W];
    assign size0 = word[0 +: SIZE_W];
    assign size1 = word[SIZE_W +: SIZE_W];

    always_comb begin
        dec = '{mx: SWZ_NONE, my: SWZ_NONE, unknown: 1'b0};
        case (cfg_kind_e'(kind))
            KIND_FIXED: begin
                dec.mx = SWZ_9_10;
                dec.my = SWZ_9;
            end
            KIND_SIZE: begin
                if (size0 == size1) begin
                    dec.mx = SWZ_9_10;
                    dec.my = SWZ_9;
                end
            end
            KIND_CHAN: begin
                if (word == '1) begin
                    dec.unknown = 1'b1;
                end else if (am == AM_ILV) begin
                    if (word[CH_XOR_OFF]) begin
                        dec.mx = SWZ_9_10;
                        dec.my = SWZ_9;
                    end else if (!word[CH_SEL17]) begin
                        dec.mx = SWZ_9_10_11;
                        dec.my = SWZ_9_11;
                    end else begin
                        dec.mx = SWZ_9_10_17;
                        dec.my = SWZ_9_17;
                    end
                end else if (am != AM_SINGLE && am != AM_ASYM) begin
                    dec.unknown = 1'b1;
                end
            end
            default: ;
        endcase
        if (dec.unknown) begin
            dec.mx = SWZ_NONE;
            dec.my = SWZ_NONE;
        end
    end
endmodule

// File: rtl/swz_mode_regs.sv
module swz_mode_regs
    import swz_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  swz_dec_t  dec,
    output swz_mode_e mx,
    output swz_mode_e my,
    output logic      pin
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mx  <= SWZ_NONE;
            my  <= SWZ_NONE;
            pin <= 1'b0;
        end else if (load) begin
            mx  <= dec.mx;
            my  <= dec.my;
            pin <= pin | dec.unknown;
        end
    end
endmodule

// File: rtl/swz_xor_lane.sv
module swz_xor_lane
    import swz_pkg::*;
(
    input  swz_mode_e mode,
    input  swz_src_t  src,
    output logic      flip
);
    assign flip = swz_flip(mode, src);
endmodule

// File: rtl/bit6_swizzler.sv
module bit6_swizzler
    import swz_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CFG_W  = 32,
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              quiesce,
    input  logic [1:0]        cfg_kind,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [1:0]        tile,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [2:0]        mode_x,
    output logic [2:0]        mode_y,
    output logic              pin_pages
);
    localparam int NLANE = 2;

    swz_dec_t   dec;
    swz_mode_e  mx_q, my_q;
    swz_src_t   src;
    logic [NLANE-1:0] flip;
    logic       flip_sel;

    swz_cfg_decode #(.CFG_W(CFG_W), .SIZE_W(SIZE_W)) u_dec (
        .kind (cfg_kind),
        .word (cfg_word),
        .dec  (dec)
    );

    swz_mode_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .load (quiesce),
        .dec  (dec),
        .mx   (mx_q),
        .my   (my_q),
        .pin  (pin_pages)
    );

    assign src = '{b17: addr_in[17], b11: addr_in[11], b10: addr_in[10], b9: addr_in[9]};

    // lane 0 serves X-tiled, lane 1 serves Y-tiled
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        swz_xor_lane u_lane (
            .mode ((g == 0) ? mx_q : my_q),
            .src  (src),
            .flip (flip[g])
        );
    end

    always_comb begin
        case (tile_e'(tile))
            TILE_X:  flip_sel = flip[0];
            TILE_Y:  flip_sel = flip[1];
            default: flip_sel = 1'b0;
        endcase
        addr_out = addr_in;
        addr_out[SWZ_DST] = addr_in[SWZ_DST] ^ flip_sel;
    end

    assign mode_x = mx_q;
    assign mode_y = my_q;
endmodule

// File: rtl/bit6_swizzler_chk.sv
module bit6_swizzler_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              quiesce,
    input logic [1:0]        tile,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [2:0]        mode_x,
    input logic [2:0]        mode_y,
    input logic              pin_pages
);
    localparam logic [ADDR_W-1:0] KEEP = ~(ADDR_W'(1) << 6);

    p_linear_r2: assert property (@(posedge clk) disable iff (rst)
        (tile == 2'b00 || tile == 2'b11) |-> addr_out == addr_in);

    p_only_bit6_r3: assert property (@(posedge clk) disable iff (rst)
        ((addr_out ^ addr_in) & KEEP) == '0);

    p_mode_legal_r5: assert property (@(posedge clk) disable iff (rst)
        mode_x != 3'd7 && mode_y != 3'd7);

    // R6, R7: X and Y modes always come in matching pairs
    p_pairing_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_x == 3'd0 && mode_y == 3'd0) || (mode_x == 3'd2 && mode_y == 3'd1) ||
        (mode_x == 3'd4 && mode_y == 3'd3) || (mode_x == 3'd6 && mode_y == 3'd5));

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        pin_pages |=> pin_pages);

    p_pin_none_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(pin_pages) |-> (mode_x == 3'd0 && mode_y == 3'd0));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !quiesce |=> ($stable(mode_x) && $stable(mode_y) && $stable(pin_pages)));
endmodule

bind bit6_swizzler bit6_swizzler_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .quiesce   (quiesce),
    .tile      (tile),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .mode_x    (mode_x),
    .mode_y    (mode_y),
    .pin_pages (pin_pages)
);

// File: tb/bit6_swizzler_bench.sv
`timescale 1ns/1ps
module bit6_swizzler_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        quiesce = 1'b0;
    logic [1:0]  cfg_kind = 2'b00;
    logic [31:0] cfg_word = '0;
    logic [1:0]  tile = 2'b00;
    logic [31:0] addr_in = '0;
    logic [31:0] addr_out;
    logic [2:0]  mode_x, mode_y;
    logic        pin_pages;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bit6_swizzler u_bit6_swizzler (
        .clk(clk), .rst(rst), .quiesce(quiesce), .cfg_kind(cfg_kind),
        .cfg_word(cfg_word), .tile(tile), .addr_in(addr_in),
        .addr_out(addr_out), .mode_x(mode_x), .mode_y(mode_y),
        .pin_pages(pin_pages)
    );

    function automatic logic exp_flip(int m, logic [31:0] a);
        case (m)
            1: return a[9];
            2: return a[9] ^ a[10];
            3: return a[9] ^ a[11];
            4: return a[9] ^ a[10] ^ a[11];
            5: return a[9] ^ a[17];
            6: return a[9] ^ a[10] ^ a[17];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_modes(string req, int ex, int ey, bit ep);
        checks++;
        if (mode_x != 3'(ex) || mode_y != 3'(ey) || pin_pages != ep) begin
            errors++;
            $display("FAIL %s: modes x=%0d y=%0d pin=%0d expected x=%0d y=%0d pin=%0d",
                     req, mode_x, mode_y, pin_pages, ex, ey, ep);
        end
    endtask

    task automatic load(string req, logic [1:0] k, logic [31:0] w, int ex, int ey, bit ep);
        @(negedge clk);
        cfg_kind = k; cfg_word = w; quiesce = 1'b1;
        @(negedge clk);
        quiesce = 1'b0;
        check_modes(req, ex, ey, ep);
    endtask

    // R2, R3, R4: sweep tiles and the source bits 6, 9, 10, 11, 17
    task automatic sweep(int mx, int my);
        for (int t = 0; t < 4; t++) begin
            for (int i = 0; i < 32; i++) begin
                logic [31:0] a;
                logic [31:0] e;
                a = (32'h5A3C_81A5 ^ (i * 32'h0103_3011)) & ~32'h0002_0E40;
                a[6] = i[0]; a[9] = i[1]; a[10] = i[2]; a[11] = i[3]; a[17] = i[4] ^ i[0];
                tile = 2'(t); addr_in = a;
                e = a;
                if (t == 1) e[6] = a[6] ^ exp_flip(mx, a);
                if (t == 2) e[6] = a[6] ^ exp_flip(my, a);
                #1;
                checks++;
                if (addr_out !== e) begin
                    errors++;
                    $display("FAIL %s: tile=%0d addr=%h got %h expected %h",
                             (t == 1) ? "R3" : (t == 2) ? "R4" : "R2 R10", t, a, addr_out, e);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_modes("R1", 0, 0, 0);
        sweep(0, 0);

        load("R7 fixed", 2'b11, 32'h0, 2, 1, 0);             sweep(2, 1);
        load("R6 xor-off", 2'b01, 32'h0000_0402, 2, 1, 0);   sweep(2, 1);
        load("R6 bit11", 2'b01, 32'h0000_0002, 4, 3, 0);     sweep(4, 3);
        load("R6 bit17", 2'b01, 32'h0000_0202, 6, 5, 0);     sweep(6, 5);
        load("R5 single", 2'b01, 32'h0000_0600, 0, 0, 0);
        load("R6 again", 2'b01, 32'h0000_0602, 2, 1, 0);
        load("R5 asym", 2'b01, 32'h0000_0201, 0, 0, 0);
        load("R7 size eq", 2'b10, 32'hFFFF_3434, 2, 1, 0);
        load("R7 size ne", 2'b10, 32'h0000_3435, 0, 0, 0);
        load("R7 off", 2'b00, 32'hFFFF_FFFF, 0, 0, 0);

        // R9: configuration changes with quiesce low are ignored
        @(negedge clk);
        cfg_kind = 2'b11; cfg_word = 32'h0;
        repeat (3) @(negedge clk);
        cfg_kind = 2'b01; cfg_word = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check_modes("R9 hold", 0, 0, 0);
        sweep(0, 0);

        // R8: reserved addressing value
        load("R8 reserved", 2'b01, 32'h0000_0003, 0, 0, 1);
        load("R8 sticky", 2'b11, 32'h0, 2, 1, 1);
        sweep(2, 1);

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_modes("R1 re-reset", 0, 0, 0);

        load("R6 pre", 2'b01, 32'h0000_0202, 6, 5, 0);
        load("R8 all-ones", 2'b01, 32'hFFFF_FFFF, 0, 0, 1);
        load("R8 stays", 2'b10, 32'h0000_0101, 2, 1, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule